// File: doc/BRIEF.md
# Receive Word Queue With Sticky Error Capture

This block is the back end of a biphase serial receiver. The line decoder in front of it hands over one decoded word per received frame, together with single-cycle strobes for framing faults. The block queues the words in a small first-in first-out store that the CPU drains one word at a time. It also keeps a byte of sticky fault flags that the CPU reads to find out what went wrong since its last look.

Five faults are captured:
- a frame that arrives while the queue is already full;
- a word whose overall bit count is odd;
- a missing end-of-frame code violation;
- a missing mid-bit transition;
- the transmitter starting while the receiver is busy, when no permission to do so was given.

A CPU read of the fault byte clears it. A transceiver reset clears both the flags and the queue.

Top module: `rx_fifo_errcap`

## Requirements
- R1: After the asynchronous reset, `empty_o` is 1 and `err_o` is 0x00.
- R2: Words leave the queue in arrival order. `rd_data_o` shows the oldest held word, and `pop_i` removes it. The queue holds up to DEPTH words.
- R3: A word that arrives while DEPTH words are held and `pop_i` is low is discarded, and the stored words are kept. On the next cycle `err_o` bit 4 (overflow) is 1.
- R4: A valid word with an odd number of 1 bits sets `err_o` bit 3 (parity). The word is still queued.
- R5: A pulse on `ies_evt_i` sets `err_o` bit 2 (bad ending sequence). The flag stays set until it is cleared.
- R6: A pulse on `lmbt_evt_i` sets `err_o` bit 1 (missing mid-bit transition).
- R7: `err_o` bit 0 is set when `tx_act_i` and `rx_busy_i` are high while `rx_permit_i` is low. With `rx_permit_i` high, or with `rx_busy_i` low, it is not set.
- R8: A cycle with `err_rd_i` high and no new fault makes `err_o` read 0x00 from the next cycle on.
- R9: A fault that occurs in the same cycle as a clearing read leaves its flag set. Flags that had no new fault in that cycle are cleared.
- R10: `trst_i` empties the queue and clears every flag on the next cycle. It overrides any push or fault in the same cycle.
- R11: Bits 7 to 5 of `err_o` always read 0.
- R12: `pop_i` on an empty queue has no effect. A push and a pop in the same cycle on a full queue stores the new word and raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wd_valid_i | input | 1 | Decoded word valid, one per completed frame |
| wd_data_i | input | DATA_W | Decoded word, parity bit included |
| ies_evt_i | input | 1 | Strobe: ending code violation missing |
| lmbt_evt_i | input | 1 | Strobe: mid-bit transition missing |
| tx_act_i | input | 1 | Strobe: transmitter being activated |
| rx_busy_i | input | 1 | Receiver is mid-frame |
| rx_permit_i | input | 1 | Permission for transmit while receiving |
| trst_i | input | 1 | Synchronous transceiver reset |
| pop_i | input | 1 | CPU read of the queue head |
| err_rd_i | input | 1 | CPU read of the fault byte |
| rd_data_o | output | DATA_W | Oldest queued word |
| empty_o | output | 1 | Queue holds no word |
| err_o | output | 8 | Fault byte: {3'b0, ovf, par, ies, lmbt, rdis} |

## Verification
The bench builds the block with its defaults, a 16-bit word and a depth of 3. With a depth of 3 the pointers wrap at a value that is not a power of two, and a full queue is reached after only three pushes. This brings the overflow discard and the push-and-pop-on-full case within a few cycles. The 16-bit width lets chosen patterns with an even or odd number of ones exercise the parity flag alongside the ordering checks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ERR_W    = 8;
  localparam int NFLAG    = 5;
  localparam int BIT_OVF  = 4;
  localparam int BIT_PAR  = 3;
  localparam int BIT_IES  = 2;
  localparam int BIT_LMBT = 1;
  localparam int BIT_RDIS = 0;
endpackage

// File: rtl/rxq_event_gen.sv
module rxq_event_gen
  import rxq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wd_valid_i,
  input  logic [DATA_W-1:0] wd_data_i,
  input  logic              full_i,
  input  logic              pop_i,
  input  logic              ies_evt_i,
  input  logic              lmbt_evt_i,
  input  logic              tx_act_i,
  input  logic              rx_busy_i,
  input  logic              rx_permit_i,
  output logic              push_ok_o,
  output logic [NFLAG-1:0]  evt_o
);
  logic odd_word;

  assign odd_word = ^wd_data_i;
  // a pop in the same cycle frees a slot for the arriving word
  assign push_ok_o = wd_valid_i & (~full_i | pop_i);

  always_comb begin
    evt_o           = '0;
    evt_o[BIT_OVF]  = wd_valid_i & full_i & ~pop_i;
    evt_o[BIT_PAR]  = wd_valid_i & odd_word;
    evt_o[BIT_IES]  = ies_evt_i;
    evt_o[BIT_LMBT] = lmbt_evt_i;
    evt_o[BIT_RDIS] = tx_act_i & rx_busy_i & ~rx_permit_i;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop_eff;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign pop_eff = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i)  wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_eff) rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_eff})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[g] <= '0;
      else if (push_i && !clr_i && wr_ptr_q == PTR_W'(g)) mem_q[g] <= push_data_i;
    end
  end
endmodule

// File: rtl/rxq_flag_bank.sv
module rxq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hard_clr_i,
  input  logic         rd_clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_o[g] <= 1'b0;
      else if (hard_clr_i) flag_o[g] <= 1'b0;
      // new event beats the clearing read
      else                 flag_o[g] <= set_i[g] | (flag_o[g] & ~rd_clr_i);
    end
  end
endmodule

// File: rtl/rx_fifo_errcap.sv
module rx_fifo_errcap
  import rxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wd_valid_i,
  input  logic [DATA_W-1:0] wd_data_i,
  input  logic              ies_evt_i,
  input  logic              lmbt_evt_i,
  input  logic              tx_act_i,
  input  logic              rx_busy_i,
  input  logic              rx_permit_i,
  input  logic              trst_i,
  input  logic              pop_i,
  input  logic              err_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [7:0]        err_o
);
  localparam int RSV_W = ERR_W - NFLAG;

  logic             fifo_full;
  logic             push_ok;
  logic [NFLAG-1:0] evt;
  logic [NFLAG-1:0] flags;

  rxq_event_gen #(.DATA_W(DATA_W)) u_evt (
    .wd_valid_i (wd_valid_i),
    .wd_data_i  (wd_data_i),
    .full_i     (fifo_full),
    .pop_i      (pop_i),
    .ies_evt_i  (ies_evt_i),
    .lmbt_evt_i (lmbt_evt_i),
    .tx_act_i   (tx_act_i),
    .rx_busy_i  (rx_busy_i),
    .rx_permit_i(rx_permit_i),
    .push_ok_o  (push_ok),
    .evt_o      (evt)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (trst_i),
    .push_i     (push_ok),
    .push_data_i(wd_data_i),
    .pop_i      (pop_i),
    .head_o     (rd_data_o),
    .empty_o    (empty_o),
    .full_o     (fifo_full)
  );

  rxq_flag_bank #(.N(NFLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hard_clr_i(trst_i),
    .rd_clr_i  (err_rd_i),
    .set_i     (evt),
    .flag_o    (flags)
  );

  assign err_o = {{RSV_W{1'b0}}, flags};
endmodule

// File: rtl/rx_fifo_errcap_chk.sv
module rx_fifo_errcap_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wd_valid_i,
  input logic [DATA_W-1:0] wd_data_i,
  input logic              ies_evt_i,
  input logic              lmbt_evt_i,
  input logic              tx_act_i,
  input logic              rx_busy_i,
  input logic              rx_permit_i,
  input logic              trst_i,
  input logic              pop_i,
  input logic              err_rd_i,
  input logic              empty_o,
  input logic [7:0]        err_o,
  input logic              fifo_full
);
  logic any_evt;
  assign any_evt = ies_evt_i | lmbt_evt_i | (tx_act_i & rx_busy_i & ~rx_permit_i)
                 | (wd_valid_i & (^wd_data_i)) | (wd_valid_i & fifo_full & ~pop_i);

  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[7:5] == 3'b000);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_valid_i && fifo_full && !pop_i && !trst_i) |=> err_o[4]);

  assert_parity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_valid_i && (^wd_data_i) && !trst_i) |=> err_o[3]);

  assert_ies_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[2] && !err_rd_i && !trst_i) |=> err_o[2]);

  assert_rdis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_act_i && rx_busy_i && !rx_permit_i && !trst_i) |=> err_o[0]);

  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_rd_i && !any_evt) |=> (err_o == 8'h00));

  assert_trst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trst_i |=> (empty_o && err_o == 8'h00));

  assert_pop_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !wd_valid_i) |=> empty_o);
endmodule

bind rx_fifo_errcap rx_fifo_errcap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wd_valid_i (wd_valid_i),
  .wd_data_i  (wd_data_i),
  .ies_evt_i  (ies_evt_i),
  .lmbt_evt_i (lmbt_evt_i),
  .tx_act_i   (tx_act_i),
  .rx_busy_i  (rx_busy_i),
  .rx_permit_i(rx_permit_i),
  .trst_i     (trst_i),
  .pop_i      (pop_i),
  .err_rd_i   (err_rd_i),
  .empty_o    (empty_o),
  .err_o      (err_o),
  .fifo_full  (fifo_full)
);

// File: tb/rx_fifo_errcap_bench.sv
`timescale 1ns/1ps
module rx_fifo_errcap_bench;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wd_valid = 0, ies = 0, lmbt = 0, tx_act = 0, rx_busy = 0, permit = 0;
  logic              trst = 0, pop = 0, err_rd = 0;
  logic [DATA_W-1:0] wd_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              empty;
  logic [7:0]        err;
  int                n_chk = 0, n_bad = 0;
  bit                done = 0;

  always #10 clk = ~clk;

  rx_fifo_errcap u_rx_fifo_errcap (
    .clk_i(clk), .rst_ni(rst_n), .wd_valid_i(wd_valid), .wd_data_i(wd_data),
    .ies_evt_i(ies), .lmbt_evt_i(lmbt), .tx_act_i(tx_act), .rx_busy_i(rx_busy),
    .rx_permit_i(permit), .trst_i(trst), .pop_i(pop), .err_rd_i(err_rd),
    .rd_data_o(rd_data), .empty_o(empty), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change at negedge; state is sampled at the following negedge
  task automatic step();
    @(negedge clk);
    wd_valid = 0; ies = 0; lmbt = 0; tx_act = 0; trst = 0; pop = 0; err_rd = 0;
  endtask

  task automatic push(input logic [DATA_W-1:0] w);
    wd_valid = 1; wd_data = w; step();
  endtask

  task automatic pop_expect(input string req, input logic [DATA_W-1:0] w);
    chk(req, {31'd0, empty}, 0);
    chk(req, rd_data, w);
    pop = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 empty", {31'd0, empty}, 1);
    chk("R1 err", err, 8'h00);
  endtask

  task automatic t_order();
    push(16'h0003); push(16'h1111); push(16'hA5A5);
    pop_expect("R2 first", 16'h0003);
    pop_expect("R2 second", 16'h1111);
    pop_expect("R2 third", 16'hA5A5);
    chk("R2 drained", {31'd0, empty}, 1);
    chk("R2 no err", err, 8'h00);
  endtask

  task automatic t_overflow();
    push(16'h00F0); push(16'h0F00); push(16'hF000);
    chk("R3 no ovf yet", err, 8'h00);
    push(16'h0033);
    chk("R3 ovf flag", err, 8'h10);
    chk("R11 reserved", {29'd0, err[7:5]}, 0);
    err_rd = 1; step();
    chk("R8 cleared", err, 8'h00);
    pop_expect("R3 kept 1", 16'h00F0);
    pop_expect("R3 kept 2", 16'h0F00);
    pop_expect("R3 kept 3", 16'hF000);
    chk("R3 discarded", {31'd0, empty}, 1);
  endtask

  task automatic t_parity();
    push(16'h0007);
    chk("R4 par flag", err, 8'h08);
    pop_expect("R4 stored", 16'h0007);
    err_rd = 1; step();
    chk("R8 par cleared", err, 8'h00);
  endtask

  task automatic t_ies_lmbt();
    ies = 1; step();
    chk("R5 ies", err, 8'h04);
    step(); step(); step();
    chk("R5 sticky", err, 8'h04);
    lmbt = 1; step();
    chk("R6 lmbt", err, 8'h06);
    err_rd = 1; step();
    chk("R8 both cleared", err, 8'h00);
  endtask

  task automatic t_rdis();
    rx_busy = 1; permit = 1; tx_act = 1; step();
    chk("R7 permitted", err, 8'h00);
    rx_busy = 0; permit = 0; tx_act = 1; step();
    chk("R7 rx idle", err, 8'h00);
    rx_busy = 1; tx_act = 1; step();
    chk("R7 rdis set", err, 8'h01);
    rx_busy = 0;
    err_rd = 1; step();
    chk("R8 rdis cleared", err, 8'h00);
  endtask

  task automatic t_race();
    ies = 1; step();
    chk("R9 pre", err, 8'h04);
    err_rd = 1; lmbt = 1; step();
    chk("R9 event wins", err, 8'h02);
    err_rd = 1; step();
    chk("R9 then clear", err, 8'h00);
  endtask

  task automatic t_trst();
    push(16'h0101); push(16'h0202);
    ies = 1; step();
    chk("R10 pre", err, 8'h04);
    trst = 1; lmbt = 1; wd_valid = 1; wd_data = 16'h0001; step();
    chk("R10 empty", {31'd0, empty}, 1);
    chk("R10 err", err, 8'h00);
  endtask

  task automatic t_edges();
    pop = 1; step();
    chk("R12 pop empty", {31'd0, empty}, 1);
    push(16'h0303);
    pop_expect("R12 after empty pop", 16'h0303);
    push(16'h0505); push(16'h0606); push(16'h0909);
    pop = 1; wd_valid = 1; wd_data = 16'h0A0A; step();
    chk("R12 no ovf", err, 8'h00);
    pop_expect("R12 seq 1", 16'h0606);
    pop_expect("R12 seq 2", 16'h0909);
    pop_expect("R12 seq 3", 16'h0A0A);
    chk("R12 drained", {31'd0, empty}, 1);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_order();
    t_overflow();
    t_parity();
    t_ies_lmbt();
    t_rdis();
    t_race();
    t_trst();
    t_edges();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule